// File: doc/BRIEF.md
# Composite Sync Vertical Sampler

This block recovers a vertical sync from an active-low composite sync stream. Every falling edge of the incoming sync starts a pixel-clock down-counter. When the counter expires, the block takes the sync level at that moment and drives it onto an active-low vertical sync output. On ordinary lines the pulse is short, so the sample lands after the pulse has ended and reads high. During the broad pulses of the vertical interval the sample reads low.

The delay is restarted by every falling edge, including the half-line equalizing and serration pulses. This gives two samples per line in the vertical interval, so the vertical transition lands on a full-line or a half-line position depending on the field. A horizontal position counter is cleared by a line-start pulse. That counter tags each edge as full-line or half-line, and the tag of the sample that moves the output becomes a field indication. An 8-bit host register sets the delay and can be read back. In phase-lock operation, a fixed pipeline of clocks sits between edge detection and the counter start.

Top module: `csync_vsampler`

## Requirements
- R1: While reset is asserted and after its release, before any sample, `vsync_n` is 1 and `field_flag` is 0.
- R2: With delay code c, when `csync_n` is first captured low at rising edge k, the sample is taken at edge k+c+6 (two synchronizer stages, one edge-detect stage, three phase-lock pipeline stages, then c+1 counter clocks). `vsync_n` then takes the level that `csync_n` had at edge k+c+4.
- R3: Every falling edge of `csync_n` starts its own sample, including half-line pulses, so two samples are taken per line when pulses are 64 clocks apart on a 128-clock line.
- R4: A falling edge whose counter start arrives at or before the edge where a pending sample would be taken cancels that sample and restarts the delay from the new edge.
- R5: An edge is tagged half-line when k − h + 1 ≥ HALF_WIN, where h is the last rising edge at which `hclr` was high. The count saturates at 2^HPOS_W − 1. When a sample changes `vsync_n`, `field_flag` takes that sample's tag (1 = half-line, 0 = full-line). A sample that leaves `vsync_n` unchanged leaves `field_flag` unchanged.
- R6: `reg_rdata` shows the last value written through `reg_we`/`reg_wdata` from the edge after the write. The register has no reset value. Each counter start uses the code held at that start.
- R7: `hclr` high at a rising edge clears the horizontal position count to zero at that edge.
- R8: `vsync_n` changes only at a sample instant given by R2 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| csync_n | input | 1 | Asynchronous active-low composite sync |
| hclr | input | 1 | Line-start pulse that clears the horizontal position count |
| reg_we | input | 1 | Host write strobe for the delay register |
| reg_wdata | input | 8 | Host write data (delay code; delay = code + 1 clocks) |
| reg_rdata | output | 8 | Delay register read-back |
| vsync_n | output | 1 | Active-low vertical sync |
| field_flag | output | 1 | 1 when the last vertical transition was on a half-line sample |

## Verification
The bench builds the block with HALF_WIN = 40 and HPOS_W = 8. All other parameters keep their defaults: phase-lock pipeline on with three stages, two synchronizer stages and an 8-bit delay. These settings make a 128-clock line with 64-clock half-line pulses enough to separate full-line edges from half-line edges. Idle gaps of 300 clocks then push the position count into saturation. Both field orders are driven under several delay codes, including 0 and 255. A close pair of edges exercises the restart.

// File: rtl/csvs_pkg.sv
package csvs_pkg;

   // Edge event travelling from the detector to the sampler.
   typedef struct packed {
      logic fire;   // a falling sync edge was seen
      logic half;   // the edge sits at a half-line position
   } csvs_trig_t;

endpackage

// File: rtl/csvs_edge.sv
module csvs_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic csync_n,
   output logic level_o,
   output logic fall_o
);

   localparam int LAST = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("csvs_edge: SYNC_STAGES must be at least 2");
   end

   logic [LAST:0] sync_q;
   logic          prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
         prev_q <= 1'b1;
      end else begin
         sync_q <= {sync_q[LAST-1:0], csync_n};
         prev_q <= sync_q[LAST];
      end
   end

   assign level_o = sync_q[LAST];
   assign fall_o  = prev_q & ~sync_q[LAST];

   // R3: an edge event lasts exactly one clock
   assert_fall_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |=> !fall_o);

endmodule

// File: rtl/csvs_pipe.sv
module csvs_pipe
   import csvs_pkg::*;
#(
   parameter int LOCK_MODE = 1,
   parameter int CLR_LAT   = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  csvs_trig_t d_i,
   output csvs_trig_t q_o
);

   if (CLR_LAT < 0) begin : g_bad_lat
      $error("csvs_pipe: CLR_LAT must not be negative");
   end

   if (LOCK_MODE != 0 && CLR_LAT > 0) begin : g_lat
      csvs_trig_t stg_q [CLR_LAT];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < CLR_LAT; i++) stg_q[i] <= '0;
         end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < CLR_LAT; i++) stg_q[i] <= stg_q[i-1];
         end
      end

      assign q_o = stg_q[CLR_LAT-1];
   end else begin : g_bypass
      assign q_o = d_i;
   end

endmodule

// File: rtl/csvs_sampler.sv
module csvs_sampler
   import csvs_pkg::*;
#(
   parameter int DLY_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  csvs_trig_t       trig_i,
   input  logic [DLY_W-1:0] code_i,
   input  logic             level_i,
   output logic             vsync_n_o,
   output logic             field_o
);

   if (DLY_W < 1) begin : g_bad_w
      $error("csvs_sampler: DLY_W must be at least 1");
   end

   logic             busy_q;
   logic [DLY_W-1:0] cnt_q;
   logic             half_q;
   logic             vs_q;
   logic             fld_q;
   logic             due;

   assign due = busy_q && (cnt_q == '0) && !trig_i.fire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         half_q <= 1'b0;
         vs_q   <= 1'b1;
         fld_q  <= 1'b0;
      end else if (trig_i.fire) begin
         busy_q <= 1'b1;
         cnt_q  <= code_i;
         half_q <= trig_i.half;
      end else if (busy_q) begin
         if (cnt_q == '0) begin
            busy_q <= 1'b0;
            vs_q   <= level_i;
            if (level_i != vs_q) fld_q <= half_q;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign vsync_n_o = vs_q;
   assign field_o   = fld_q;

   assert_load_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
      trig_i.fire |=> (busy_q && cnt_q == $past(code_i)));

   assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cnt_q != '0 && !trig_i.fire) |=> (cnt_q == $past(cnt_q) - 1'b1));

   assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && trig_i.fire) |=> (busy_q && half_q == $past(trig_i.half)));

   assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !due |=> $stable(vs_q));

   assert_field_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(vs_q) |-> $stable(fld_q));

endmodule

// File: rtl/csync_vsampler.sv
module csync_vsampler
   import csvs_pkg::*;
#(
   parameter int DLY_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int LOCK_MODE   = 1,
   parameter int CLR_LAT     = 3,
   parameter int HPOS_W      = 11,
   parameter int HALF_WIN    = 256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             csync_n,
   input  logic             hclr,
   input  logic             reg_we,
   input  logic [DLY_W-1:0] reg_wdata,
   output logic [DLY_W-1:0] reg_rdata,
   output logic             vsync_n,
   output logic             field_flag
);

   localparam logic [HPOS_W-1:0] HPOS_MAX = {HPOS_W{1'b1}};
   localparam logic [HPOS_W-1:0] HWIN     = HPOS_W'(HALF_WIN);

   if (HALF_WIN < 1 || HALF_WIN > (2 ** HPOS_W) - 1) begin : g_bad_win
      $error("csync_vsampler: HALF_WIN must fit in HPOS_W bits");
   end

   // Host delay register: deliberately without reset.
   logic [DLY_W-1:0] dly_code;
   always_ff @(posedge clk) begin
      if (reg_we) dly_code <= reg_wdata;
   end
   assign reg_rdata = dly_code;

   // Horizontal position since the last line-start pulse, saturating.
   logic [HPOS_W-1:0] hpos_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 hpos_q <= '0;
      else if (hclr)              hpos_q <= '0;
      else if (hpos_q != HPOS_MAX) hpos_q <= hpos_q + 1'b1;
   end

   logic       level;
   logic       fall;
   csvs_trig_t det;
   csvs_trig_t trig;

   csvs_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .csync_n (csync_n),
      .level_o (level),
      .fall_o  (fall)
   );

   assign det.fire = fall;
   assign det.half = (hpos_q >= HWIN);

   csvs_pipe #(.LOCK_MODE(LOCK_MODE), .CLR_LAT(CLR_LAT)) u_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (det),
      .q_o   (trig)
   );

   csvs_sampler #(.DLY_W(DLY_W)) u_smp (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig_i    (trig),
      .code_i    (dly_code),
      .level_i   (level),
      .vsync_n_o (vsync_n),
      .field_o   (field_flag)
   );

   assert_hpos_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hclr |=> (hpos_q == '0));

   assert_hpos_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!hclr && hpos_q != HPOS_MAX) |=> (hpos_q == $past(hpos_q) + 1'b1));

endmodule

// File: tb/test_csync_vsampler.sv
`timescale 1ns/1ps
module test_csync_vsampler;

   localparam int HWIN = 40;
   localparam int HW   = 8;
   localparam int HSAT = (1 << HW) - 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       csync_n = 1'b1;
   logic       hclr = 1'b0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       vsync_n;
   logic       field_flag;

   always #2 clk = ~clk;

   csync_vsampler #(.HPOS_W(HW), .HALF_WIN(HWIN)) i_csync_vsampler (
      .clk        (clk),
      .rst_n      (rst_n),
      .csync_n    (csync_n),
      .hclr       (hclr),
      .reg_we     (reg_we),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .vsync_n    (vsync_n),
      .field_flag (field_flag)
   );

   typedef struct { int s; int lc; bit half; } exp_t;
   exp_t q[$];

   int  cyc = 0;
   int  vectors = 0;
   int  errors = 0;
   int  code = 0;
   int  last_h = 0;
   bit  running = 1'b0;
   bit  exp_vs = 1'b1;
   bit  exp_fld = 1'b0;
   bit  hist[int];

   always @(posedge clk) begin
      cyc++;
      hist[cyc] = csync_n;
   end

   task automatic check(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
      end
   endtask

   // Monitor: pops expected samples when due and compares every cycle.
   always @(negedge clk) begin
      if (running) begin
         if (q.size() != 0 && q[0].s == cyc) begin
            exp_t it;
            bit   lv;
            it = q.pop_front();
            lv = hist[it.lc];
            if (lv != exp_vs) begin
               exp_fld = it.half;   // R5: tag of the transition sample
               exp_vs  = lv;
            end
         end
         check("R2/R8 vsync_n", vsync_n, exp_vs);
         check("R5 field_flag", field_flag, exp_fld);
      end
   end

   // Driver: one sync pulse; entered just after a falling clock edge.
   task automatic pulse(input int low, input int period, input bit line_start);
      int   n;
      int   d;
      exp_t it;
      n = cyc;
      csync_n = 1'b0;
      hclr = line_start;                 // R7: line start clears position
      if (line_start) last_h = n;
      d = n - last_h + 1;
      if (d > HSAT) d = HSAT;
      it.s    = n + 7 + code;            // R2 timing
      it.lc   = n + 5 + code;
      it.half = (d >= HWIN);
      if (q.size() != 0 && q[$].s >= n + 6) void'(q.pop_back()); // R4
      q.push_back(it);
      @(negedge clk);
      hclr = 1'b0;
      repeat (low - 1) @(negedge clk);
      csync_n = 1'b1;
      repeat (period - low) @(negedge clk);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_code(input int v);
      reg_we = 1'b1;
      reg_wdata = 8'(v);
      @(negedge clk);
      reg_we = 1'b0;
      code = v;
      check("R6 readback", reg_rdata, v);
   endtask

   task automatic normal_lines(input int n);
      for (int i = 0; i < n; i++) pulse(9, 128, 1'b1);
   endtask

   // Vertical interval; odd_start places the broad pulses at half-line.
   task automatic vertical(input bit odd_start);
      if (odd_start) pulse(9, 64, 1'b1);
      for (int i = 0; i < 6; i++) pulse(4, 64, (i % 2 == 0) ^ odd_start);  // R3
      for (int i = 0; i < 6; i++) pulse(54, 64, (i % 2 == 0) ^ odd_start);
      for (int i = 0; i < 6; i++) pulse(4, 64, (i % 2 == 0) ^ odd_start);
      normal_lines(3);
   endtask

   initial begin
      #200000000;
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      check("R1 reset vsync_n", vsync_n, 1);
      check("R1 reset field_flag", field_flag, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release vsync_n", vsync_n, 1);
      check("R1 after release field_flag", field_flag, 0);
      running = 1'b1;

      write_code(15);
      normal_lines(4);
      vertical(1'b1);          // half-line field: flag goes to 1 (R5)
      idle(40);
      check("R5 half-line field", field_flag, 1);
      normal_lines(2);
      vertical(1'b0);          // full-line field: flag back to 0
      idle(40);
      check("R5 full-line field", field_flag, 0);

      idle(300);
      write_code(3);
      normal_lines(2);
      vertical(1'b1);
      idle(300);

      write_code(0);           // boundary: shortest delay samples inside the pulse
      normal_lines(3);
      vertical(1'b0);
      normal_lines(2);
      idle(300);

      write_code(255);         // boundary: longest delay
      for (int i = 0; i < 3; i++) pulse(9, 300, 1'b1);
      pulse(120, 300, 1'b1);
      idle(300);

      write_code(15);          // R4: close pair restarts the delay
      normal_lines(2);
      pulse(3, 8, 1'b1);
      pulse(40, 128, 1'b1);
      normal_lines(2);
      pulse(3, 6, 1'b0);
      pulse(40, 128, 1'b1);
      normal_lines(2);

      write_code(31);
      vertical(1'b1);
      idle(300);
      check("R6 final readback", reg_rdata, 31);
      check("R8 queue drained", q.size(), 0);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule